// File: doc/BRIEF.md
# Single-Window Queue Ticket Controller

This block runs the ticket logic for a queue served at one window. A customer button asks for a new ticket and a clerk button reports that a service is finished. Each button is synchronised and edge-detected inside the block, so a press counts once no matter how long the button is held.

The block keeps three counters:
- the last ticket issued;
- the number last called to the window;
- the current queue length.

All three leave the block as packed two-digit BCD, ready for a seven-segment display driver. A queue-full alarm flag goes with them.

When the queue already holds the limit (99 by default), a new request is refused and the alarm is raised. Ticket numbers start at 01 and run up to 99, then wrap back to 01. The called number follows the same sequence, so after each completion it shows the ticket of the customer just called.

Top module: `queue_ticket_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `ticket_bcd`, `served_bcd` and `length_bcd` read 8'h00 and `alarm` is 0.
- R2: Every count output is packed BCD: tens digit in bits 7:4, units digit in bits 3:0, each digit between 0 and 9.
- R3: An accepted join adds one to `length_bcd` and advances `ticket_bcd`. The first ticket after reset is 8'h01.
- R4: The ticket and called-number sequences go from 8'h99 to 8'h01, never to 8'h00.
- R5: A join while the length equals the limit, with no completion in the same cycle, is refused. The length and the ticket stay unchanged and `alarm` goes to 1.
- R6: Once raised, `alarm` stays at 1 until the length drops below the limit or reset is applied. It is 1 only while the length equals the limit.
- R7: A completion while the length is nonzero lowers the length by one and advances `served_bcd`.
- R8: A completion while the length is 0 has no effect on `served_bcd` or `length_bcd`.
- R9: A join and a completion in the same cycle behave as follows:
  - with a nonzero length, the length is unchanged and both the ticket and the called number advance, even at the limit, where `alarm` keeps its value;
  - with a length of 0, only the join takes effect.
- R10: A button change passes two synchronising flops. Its rising edge changes the outputs on the third rising clock edge after the input goes high. A held button acts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| join_btn | input | 1 | Customer ticket request button, asynchronous |
| done_btn | input | 1 | Clerk service-complete button, asynchronous |
| ticket_bcd | output | 8 | Last ticket issued, packed BCD |
| served_bcd | output | 8 | Ticket number last called to the window, packed BCD |
| length_bcd | output | 8 | Current queue length, packed BCD |
| alarm | output | 1 | Queue-full alarm after a refused join |

## Verification
On every cycle the assertions check:
- that the digits stay legal BCD;
- that the length never exceeds the limit and moves by at most one step;
- that the alarm only appears at a full queue;
- that a completion against an empty queue leaves the called number alone;
- that tickets only move to their wrapped successor.

The bench's scenarios are needed for the rest:
- the exact three-edge latency;
- the single action of a held button;
- the wrap from 99 to 01 after a long run of joins;
- the outcome of simultaneous presses at empty, mid and full lengths;
- the alarm clearing on a completion and on reset.

// File: rtl/qt_pkg.sv
package qt_pkg;

    typedef logic [7:0] bcd2_t;

    localparam bcd2_t BCD_ZERO = 8'h00;
    localparam bcd2_t BCD_ONE  = 8'h01;
    localparam bcd2_t BCD_TOP  = 8'h99;

    typedef struct packed {
        bcd2_t ticket;
        bcd2_t served;
        bcd2_t length;
        logic  alarm;
    } qt_state_t;

    function automatic bcd2_t bcd_from_int(input int unsigned n);
        bcd2_t r;
        r[7:4] = 4'((n / 10) % 10);
        r[3:0] = 4'(n % 10);
        return r;
    endfunction

    function automatic bcd2_t bcd_inc(input bcd2_t v);
        bcd2_t r;
        if (v[3:0] == 4'd9) begin
            r[3:0] = 4'd0;
            r[7:4] = (v[7:4] == 4'd9) ? 4'd0 : v[7:4] + 4'd1;
        end else begin
            r[3:0] = v[3:0] + 4'd1;
            r[7:4] = v[7:4];
        end
        return r;
    endfunction

    function automatic bcd2_t bcd_dec(input bcd2_t v);
        bcd2_t r;
        if (v[3:0] == 4'd0) begin
            r[3:0] = 4'd9;
            r[7:4] = v[7:4] - 4'd1;
        end else begin
            r[3:0] = v[3:0] - 4'd1;
            r[7:4] = v[7:4];
        end
        return r;
    endfunction

    // Ticket sequence: 01..99 then back to 01.
    function automatic bcd2_t ticket_next(input bcd2_t v);
        return (v == BCD_TOP) ? BCD_ONE : bcd_inc(v);
    endfunction

endpackage

// File: rtl/qt_btn_edge.sv
module qt_btn_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_async,
    output logic rise_pulse
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [LAST:0] sync;
        logic          prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[LAST-1:0], btn_async};
        st_d.prev = st_q.sync[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_pulse = st_q.sync[LAST] & ~st_q.prev;

endmodule

// File: rtl/qt_queue_core.sv
module qt_queue_core
    import qt_pkg::*;
#(
    parameter int LEN_LIMIT = 99
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  join_pulse,
    input  logic  done_pulse,
    output bcd2_t ticket,
    output bcd2_t served,
    output bcd2_t length,
    output logic  alarm
);
    localparam bcd2_t LIMIT_BCD = bcd_from_int(LEN_LIMIT);

    qt_state_t st_d, st_q;
    logic done_ok;
    logic join_ok;

    always_comb begin
        st_d    = st_q;
        done_ok = done_pulse && (st_q.length != BCD_ZERO);
        // A completion in the same cycle frees a slot for the join.
        join_ok = join_pulse && ((st_q.length != LIMIT_BCD) || done_ok);

        if (join_ok) begin
            st_d.ticket = ticket_next(st_q.ticket);
        end
        if (done_ok) begin
            st_d.served = ticket_next(st_q.served);
        end

        if (join_ok && !done_ok) begin
            st_d.length = bcd_inc(st_q.length);
        end else if (done_ok && !join_ok) begin
            st_d.length = bcd_dec(st_q.length);
        end

        st_d.alarm = (join_pulse && !join_ok) ||
                     (st_q.alarm && (st_d.length == LIMIT_BCD));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ticket = st_q.ticket;
    assign served = st_q.served;
    assign length = st_q.length;
    assign alarm  = st_q.alarm;

endmodule

// File: rtl/queue_ticket_ctrl.sv
module queue_ticket_ctrl #(
    parameter int LEN_LIMIT   = 99,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       join_btn,
    input  logic       done_btn,
    output logic [7:0] ticket_bcd,
    output logic [7:0] served_bcd,
    output logic [7:0] length_bcd,
    output logic       alarm
);
    localparam int N_BTN = 2;

    logic [N_BTN-1:0] btn_raw;
    logic [N_BTN-1:0] btn_rise;

    assign btn_raw = {done_btn, join_btn};

    for (genvar i = 0; i < N_BTN; i++) begin : g_btn
        qt_btn_edge #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .btn_async (btn_raw[i]),
            .rise_pulse(btn_rise[i])
        );
    end

    qt_queue_core #(
        .LEN_LIMIT(LEN_LIMIT)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .join_pulse(btn_rise[0]),
        .done_pulse(btn_rise[1]),
        .ticket    (ticket_bcd),
        .served    (served_bcd),
        .length    (length_bcd),
        .alarm     (alarm)
    );

endmodule

// File: rtl/qt_checker.sv
module qt_checker
    import qt_pkg::*;
#(
    parameter int LEN_LIMIT = 99
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ticket_bcd,
    input logic [7:0] served_bcd,
    input logic [7:0] length_bcd,
    input logic       alarm
);
    localparam bcd2_t LIMIT_BCD = bcd_from_int(LEN_LIMIT);

    a_r1_reset_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (length_bcd == 8'h00 && !alarm));

    a_r2_bcd_digits: assert property (@(posedge clk) disable iff (!rst_n)
        (length_bcd[3:0] <= 4'd9 && length_bcd[7:4] <= 4'd9 &&
         ticket_bcd[3:0] <= 4'd9 && ticket_bcd[7:4] <= 4'd9 &&
         served_bcd[3:0] <= 4'd9 && served_bcd[7:4] <= 4'd9));

    a_r5_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        length_bcd <= LIMIT_BCD);

    a_r3_len_step: assert property (@(posedge clk) disable iff (!rst_n)
        (length_bcd != $past(length_bcd)) |->
            (length_bcd == bcd_inc($past(length_bcd)) ||
             length_bcd == bcd_dec($past(length_bcd))));

    a_r4_ticket_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ticket_bcd != $past(ticket_bcd)) |->
            (ticket_bcd == ticket_next($past(ticket_bcd))));

    a_r6_alarm_full: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> (length_bcd == LIMIT_BCD));

    a_r8_empty_served: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(length_bcd) == 8'h00) |-> (served_bcd == $past(served_bcd)));

endmodule

bind queue_ticket_ctrl qt_checker #(
    .LEN_LIMIT(LEN_LIMIT)
) u_qt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ticket_bcd(ticket_bcd),
    .served_bcd(served_bcd),
    .length_bcd(length_bcd),
    .alarm     (alarm)
);

// File: tb/queue_ticket_ctrl_bench.sv
`timescale 1ns/1ps
module queue_ticket_ctrl_bench;

    localparam int LIMIT = 99;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       join_btn = 1'b0;
    logic       done_btn = 1'b0;
    logic [7:0] ticket_bcd;
    logic [7:0] served_bcd;
    logic [7:0] length_bcd;
    logic       alarm;

    int n_checks = 0;
    int n_fail   = 0;
    int m_ticket = 0;
    int m_served = 0;
    int m_len    = 0;
    bit m_alarm  = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    queue_ticket_ctrl u_queue_ticket_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .join_btn  (join_btn),
        .done_btn  (done_btn),
        .ticket_bcd(ticket_bcd),
        .served_bcd(served_bcd),
        .length_bcd(length_bcd),
        .alarm     (alarm)
    );

    function automatic logic [7:0] to_bcd(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic int wrap_next(input int n);
        return (n == 99) ? 1 : n + 1;
    endfunction

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check8(req, "ticket", ticket_bcd, to_bcd(m_ticket));
        check8(req, "served", served_bcd, to_bcd(m_served));
        check8(req, "length", length_bcd, to_bcd(m_len));
        check8(req, "alarm", {7'd0, alarm}, {7'd0, m_alarm});
    endtask

    // Press one or both buttons, hold, release, let the pipeline settle,
    // then apply the requirement arithmetic to the model and compare.
    task automatic press(input bit j, input bit d, input int hold, input string req);
        bit dacc;
        bit jacc;
        @(negedge clk);
        join_btn = j;
        done_btn = d;
        repeat (hold) @(negedge clk);
        join_btn = 1'b0;
        done_btn = 1'b0;
        repeat (4) @(negedge clk);
        dacc = d && (m_len > 0);
        jacc = j && ((m_len < LIMIT) || dacc);
        if (jacc) m_ticket = wrap_next(m_ticket);
        if (dacc) m_served = wrap_next(m_served);
        if (jacc && !dacc) m_len++;
        else if (dacc && !jacc) m_len--;
        m_alarm = (j && !jacc) || (m_alarm && m_len == LIMIT);
        check_all(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_ticket = 0; m_served = 0; m_len = 0; m_alarm = 1'b0;
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        do_reset();

        // R10: latency of exactly three rising edges after the input rises.
        @(negedge clk);
        join_btn = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check8("R10 before third edge", "length", length_bcd, 8'h00);
        @(negedge clk);
        check8("R10 on third edge", "length", length_bcd, 8'h01);
        check8("R3 first ticket", "ticket", ticket_bcd, 8'h01);
        join_btn = 1'b0;
        repeat (4) @(negedge clk);
        m_ticket = 1; m_len = 1;
        check_all("R10 R3 single join");

        press(1'b0, 1'b1, 2, "R7 completion");
        press(1'b0, 1'b1, 2, "R8 completion at empty");

        // R3, R4, R2: fill the queue; the ticket wraps from 99 to 01 on the way.
        for (int i = 0; i < LIMIT; i++) begin
            press(1'b1, 1'b0, 2, "R3 R4 R2 fill");
        end
        check8("R4 ticket wrapped", "ticket", ticket_bcd, 8'h01);

        press(1'b1, 1'b0, 2, "R5 join when full");
        press(1'b1, 1'b0, 25, "R10 held join while full");
        press(1'b1, 1'b1, 2, "R9 R6 both at full");
        press(1'b0, 1'b1, 2, "R6 alarm clears below limit");
        press(1'b1, 1'b1, 2, "R9 both mid-length");

        // R7: drain the queue; the called number wraps past 99.
        for (int i = 0; i < LIMIT - 1; i++) begin
            press(1'b0, 1'b1, 2, "R7 R4 drain");
        end
        press(1'b0, 1'b1, 30, "R10 R8 held completion at empty");
        press(1'b1, 1'b1, 2, "R9 both at empty");

        while (m_len < LIMIT) press(1'b1, 1'b0, 2, "R3 refill");
        press(1'b1, 1'b0, 2, "R5 alarm again");
        do_reset();

        summary();
    end

endmodule